// File: doc/BRIEF.md
# UART Receive Buffer with Error Flagging

This block sits between a UART receive shift register and the CPU. The shift register hands it each finished frame as a single-cycle strobe. The strobe carries the data byte, the sampled stop bit and the result of the parity check. The block keeps up to two received bytes in arrival order, and the CPU sees the oldest one on a read port. Each stored byte keeps its own framing and parity status. A byte with an error is still stored like any other byte.

Error flags follow the byte the CPU will read next, not the moment a bad frame arrives. If an errored byte lands in an empty buffer, its flag is raised at once. If it lands behind a byte that is already waiting, its flag is raised only when the CPU reads that earlier byte out. A frame that completes while both entries are full is dropped and raises an overrun flag. All three flags are sticky and are cleared by writing 1. Each flag is gated by its own enable to form a single interrupt line.

Top module: `uart_rxbuf`

## Requirements
- R1: After reset `rxValid`, `rxData`, `errFlags` and `irq` are all 0.
- R2: The buffer holds up to two bytes in arrival order. `rxData` shows the oldest byte while `rxValid` is 1. A cycle with `rdEn` high and `rxValid` high removes that byte, and the next byte becomes visible after the clock edge.
- R3: A frame whose stop bit (`frameStop`) is 0 is a framing error and is reported in `errFlags` bit 0. The byte is still stored and later read like any other byte.
- R4: A frame with `frameParityOk` low is a parity error and is reported in `errFlags` bit 1. The byte is still stored.
- R5: When an errored frame arrives while the buffer is empty, or arrives in the same cycle as a read of the only stored byte, its error bits are set in the same clock edge that makes it the visible byte.
- R6: When an errored frame goes into the second entry, its error bits stay clear until the cycle in which the CPU reads the first byte. They are set on that clock edge.
- R7: A frame that completes while two bytes are stored and `rdEn` is low sets `errFlags` bit 2 (overrun) and is discarded. A frame that completes while two bytes are stored and a read happens in the same cycle is stored and raises no overrun.
- R8: Flags are sticky. In a cycle with `clrEn` high, each flag whose `clrMask` bit is 1 is cleared. If a flag is set and cleared in the same cycle, it ends set.
- R9: `irq` is 1 exactly when some flag bit is 1 and the `intEn` bit at the same position is 1.
- R10: A read while the buffer is empty leaves `rxData`, `rxValid` and the flags unchanged. `rxData` keeps the last byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe: a frame has completed |
| frameData | input | DATA_W | Received data byte |
| frameStop | input | 1 | Sampled stop bit value |
| frameParityOk | input | 1 | 1 when the parity check passed |
| rdEn | input | 1 | CPU read of the visible byte |
| clrEn | input | 1 | Flag clear write strobe |
| clrMask | input | 3 | Write-1-to-clear mask, bits {overrun, parity, framing} |
| intEn | input | 3 | Interrupt enables, same bit order as the flags |
| rxData | output | DATA_W | Oldest stored byte, or the last byte read |
| rxValid | output | 1 | At least one byte is stored |
| errFlags | output | 3 | Sticky flags: bit 0 framing, bit 1 parity, bit 2 overrun |
| irq | output | 1 | Enabled-flag interrupt |

## Verification
The assertions assume `frameValid` is a single-cycle pulse that does not depend on the buffer's fill level. They also assume `rdEn` and `clrEn` are sampled only at clock edges. A read in an empty cycle is treated as legal and must be harmless. The bench changes every input shortly after a rising edge and holds it for the whole cycle, so each strobe lasts exactly one cycle. It aims the frame strobe at each fill level, including the full buffer with and without a read in the same cycle.

// File: rtl/uart_rxbuf_pkg.sv
package uart_rxbuf_pkg;
  localparam int FLAG_W = 3;
  localparam int FLAG_FE = 0;
  localparam int FLAG_PE = 1;
  localparam int FLAG_OE = 2;

  typedef struct packed {
    logic headFromIn;
    logic headFromTail;
    logic tailFromIn;
  } bufCtrl_t;
endpackage

// File: rtl/rxbuf_datapath.sv
module rxbuf_datapath
  import uart_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCtrl_t          ctrl,
  input  logic [DATA_W-1:0] inData,
  input  logic              inFe,
  input  logic              inPe,
  output logic [DATA_W-1:0] headData,
  output logic              tailFe,
  output logic              tailPe
);
  logic [DATA_W-1:0] tailData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headData <= '0;
      tailData <= '0;
      tailFe   <= 1'b0;
      tailPe   <= 1'b0;
    end else begin
      if (ctrl.headFromIn)        headData <= inData;
      else if (ctrl.headFromTail) headData <= tailData;
      if (ctrl.tailFromIn) begin
        tailData <= inData;
        tailFe   <= inFe;
        tailPe   <= inPe;
      end
    end
  end

  AST_HEAD_ONE_SRC: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctrl.headFromIn, ctrl.headFromTail})); // R2

  AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.tailFromIn |=> $stable(tailData)); // R2
endmodule

// File: rtl/rxbuf_ctrl.sv
module rxbuf_ctrl
  import uart_rxbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic              inFe,
  input  logic              inPe,
  input  logic              tailFe,
  input  logic              tailPe,
  input  logic              rdEn,
  input  logic              clrEn,
  input  logic [FLAG_W-1:0] clrMask,
  input  logic [FLAG_W-1:0] intEn,
  output bufCtrl_t          ctrl,
  output logic              rxValid,
  output logic [FLAG_W-1:0] errFlags,
  output logic              irq
);
  logic [1:0]        cnt, cntNext;
  logic              doRead, overrun;
  logic [FLAG_W-1:0] setMask, clrBits;

  assign doRead = rdEn && (cnt != 2'd0);

  always_comb begin
    ctrl    = '0;
    cntNext = cnt;
    overrun = 1'b0;
    unique case (cnt)
      2'd0: if (frameValid) begin
        ctrl.headFromIn = 1'b1;
        cntNext         = 2'd1;
      end
      2'd1: begin
        if (frameValid && doRead)  ctrl.headFromIn = 1'b1;
        else if (frameValid) begin
          ctrl.tailFromIn = 1'b1;
          cntNext         = 2'd2;
        end else if (doRead)       cntNext = 2'd0;
      end
      default: begin
        if (doRead) begin
          ctrl.headFromTail = 1'b1;
          ctrl.tailFromIn   = frameValid;
          cntNext           = frameValid ? 2'd2 : 2'd1;
        end else if (frameValid) begin
          overrun = 1'b1;
        end
      end
    endcase
  end

  always_comb begin
    setMask          = '0;
    setMask[FLAG_OE] = overrun;
    if (ctrl.headFromIn) begin
      setMask[FLAG_FE] = inFe;
      setMask[FLAG_PE] = inPe;
    end else if (ctrl.headFromTail) begin
      setMask[FLAG_FE] = tailFe;
      setMask[FLAG_PE] = tailPe;
    end
  end

  assign clrBits = clrEn ? clrMask : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt      <= 2'd0;
      errFlags <= '0;
    end else begin
      cnt      <= cntNext;
      errFlags <= (errFlags & ~clrBits) | setMask;
    end
  end

  assign rxValid = (cnt != 2'd0);
  assign irq     = |(errFlags & intEn);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= 2'd2); // R2

  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && cnt == 2'd2 && !rdEn) |=> (errFlags[FLAG_OE] && cnt == 2'd2)); // R7

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && cnt == 2'd0 && !frameValid && !clrEn) |=> (cnt == 2'd0 && $stable(errFlags))); // R10

  AST_CLR_OE: assert property (@(posedge clk) disable iff (!rstN)
    (clrEn && clrMask[FLAG_OE] && !(frameValid && cnt == 2'd2 && !rdEn)) |=> !errFlags[FLAG_OE]); // R8
endmodule

// File: rtl/uart_rxbuf.sv
module uart_rxbuf
  import uart_rxbuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameStop,
  input  logic              frameParityOk,
  input  logic              rdEn,
  input  logic              clrEn,
  input  logic [2:0]        clrMask,
  input  logic [2:0]        intEn,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic [2:0]        errFlags,
  output logic              irq
);
  bufCtrl_t ctrl;
  logic     inFe, inPe, tailFe, tailPe;

  assign inFe = ~frameStop;
  assign inPe = ~frameParityOk;

  rxbuf_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid),
    .inFe(inFe), .inPe(inPe), .tailFe(tailFe), .tailPe(tailPe),
    .rdEn(rdEn), .clrEn(clrEn), .clrMask(clrMask), .intEn(intEn),
    .ctrl(ctrl), .rxValid(rxValid), .errFlags(errFlags), .irq(irq)
  );

  rxbuf_datapath #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .inData(frameData), .inFe(inFe), .inPe(inPe),
    .headData(rxData), .tailFe(tailFe), .tailPe(tailPe)
  );
endmodule

// File: tb/tb_uart_rxbuf.sv
module tb_uart_rxbuf;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0, frameStop = 1'b1, frameParityOk = 1'b1;
  logic [7:0] frameData = '0;
  logic       rdEn = 1'b0, clrEn = 1'b0;
  logic [2:0] clrMask = '0, intEn = '0;
  logic [7:0] rxData;
  logic       rxValid, irq;
  logic [2:0] errFlags;
  int         nChecks = 0, nErrors = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  uart_rxbuf dut (.*);

  // fields: fv, data, stop, parOk, rd, clr, mask | expValid, expData, expFlags
  localparam int NV = 20;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 8'hA5, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'hA5, 3'b000}, // R2 store
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'hA5, 3'b000}, // R2 pop
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'hA5, 3'b000}, // R10 empty read
    {1'b1, 8'h3C, 1'b0, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'h3C, 3'b001}, // R3 R5
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'b001, 1'b1, 8'h3C, 3'b000}, // R8 clear
    {1'b1, 8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 8'h3C, 3'b000}, // R6 delayed
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 8'h77, 3'b010}, // R4 R6
    {1'b1, 8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'h77, 3'b010}, // R2
    {1'b1, 8'h22, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'h77, 3'b110}, // R7 overrun
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 8'h11, 3'b110}, // R7 R8 sticky
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'h11, 3'b110}, // R7 discarded
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'b111, 1'b0, 8'h11, 3'b000}, // R8
    {1'b1, 8'h5A, 1'b0, 1'b0, 1'b0, 1'b0, 3'b000, 1'b1, 8'h5A, 3'b011}, // R3 R4 R5
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 3'b011, 1'b1, 8'h5A, 3'b000}, // R8
    {1'b1, 8'h99, 1'b0, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 8'h99, 3'b001}, // R5 read+write
    {1'b1, 8'h42, 1'b1, 1'b1, 1'b0, 1'b0, 3'b000, 1'b1, 8'h99, 3'b001}, // R2
    {1'b1, 8'h81, 1'b1, 1'b0, 1'b1, 1'b0, 3'b000, 1'b1, 8'h42, 3'b001}, // R7 no overrun
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b1, 8'h81, 3'b011}, // R6
    {1'b1, 8'hE0, 1'b0, 1'b1, 1'b1, 1'b1, 3'b011, 1'b1, 8'hE0, 3'b001}, // R8 set wins
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 3'b000, 1'b0, 8'hE0, 3'b001}  // R10
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;
    check("R1 rxValid", rxValid, 0);
    check("R1 rxData", rxData, 0);
    check("R1 errFlags", errFlags, 0);
    check("R1 irq", irq, 0);

    for (int i = 0; i < NV; i++) begin
      {frameValid, frameData, frameStop, frameParityOk, rdEn, clrEn, clrMask} = VEC[i][27:12];
      @(posedge clk);
      #2;
      frameValid = 1'b0; rdEn = 1'b0; clrEn = 1'b0;
      check($sformatf("R2 valid step %0d", i), rxValid, VEC[i][11]);
      check($sformatf("R2 data step %0d", i), rxData, VEC[i][10:3]);
      check($sformatf("R5 R6 flags step %0d", i), errFlags, VEC[i][2:0]);
    end

    // flags now 001: R9 gating
    intEn = 3'b001; #1;
    check("R9 irq enabled", irq, 1);
    intEn = 3'b110; #1;
    check("R9 irq masked", irq, 0);
    intEn = 3'b000;

    // R10: read on empty with enables off, data held
    rdEn = 1'b1;
    @(posedge clk); #2 rdEn = 1'b0;
    check("R10 empty data", rxData, 8'hE0);
    check("R10 empty flags", errFlags, 3'b001);

    // R1: reset clears everything
    rstN = 1'b0;
    @(posedge clk); #2 rstN = 1'b1;
    check("R1 flags after reset", errFlags, 0);
    check("R1 data after reset", rxData, 0);
    finishRun();
  end
endmodule